// File: doc/BRIEF.md
# Two-Bank Masked Interrupt Controller

This block gathers sixteen interrupt inputs, in two byte-wide groups called bank A and bank B, into a single IRQ line for the processor. A third byte-wide group of inputs drives a separate fast-interrupt (FIQ) line through a mask of its own. In bank A, a parameter picks the inputs that are edge-latched: a rising edge on one of them sets a sticky bit that stays set until software clears it. The timer expiry pulses arrive on bits 5 and 6 of bank A and are edge-latched in the default setting. Every other input is level-sensitive, so its status bit follows the live pin.

Software reaches the block through a byte register port. Each group exposes three byte registers: a status register showing what is active regardless of the mask, a request register showing status AND mask, and a writable mask register. Writing a byte to the bank A request address clears the latched bits where that byte has ones. IRQ is the OR of every bank A and bank B request bit. FIQ is the OR of the fast-group request bits. Both outputs and the read data are registered.

Top module: `dual_bank_intc`

## Requirements
- R1: After a synchronous reset, all three masks, every latched bit, irq, fiq and bus_rdata are zero.
- R2: A level-sensitive input (bank A bits not selected by EDGE_A, every bank B bit, every fast-group bit) shows in its group's status register with the value it had in the cycle the read address was presented.
- R3: An edge-latched bank A input (default bits 2, 5 and 6, with timer 0 on bit 5 and timer 1 on bit 6) sets its status bit on a 0-to-1 change and holds it after the input falls; an input held high does not set the bit again once it has been cleared.
- R4: A write to the bank A request address (0x1) clears exactly the latched bits where bus_wdata is 1; other latched bits, level bits and all of bank B are unaffected, and a write to the bank B request address (0x5) changes nothing.
- R5: When a rising edge and a clear of the same latched bit fall in the same cycle, the bit ends up set.
- R6: Each request register reads as that group's status AND its mask.
- R7: irq is 1 in the cycle after any bank A or bank B request bit is 1, and 0 in the cycle after both masks are zero.
- R8: fiq is 1 in the cycle after any fast-group input is 1 with its fast mask bit set, is 0 whenever the fast mask is zero, and the fast group has no effect on irq.
- R9: The mask registers sit at 0x2 (A), 0x6 (B) and 0xA (fast) and read back what was written; writes to the status addresses 0x0, 0x4 and 0x8 have no effect.
- R10: bus_rdata is registered: it shows the register selected by bus_addr one cycle after it is presented. Address bits [3:2] select the group (0 A, 1 B, 2 fast), bits [1:0] select the register (0 status, 1 request, 2 mask), and any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_a | input | 8 | Bank A interrupt inputs |
| src_b | input | 8 | Bank B interrupt inputs (level) |
| src_f | input | 8 | Fast-interrupt inputs (level) |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Register address: group in [3:2], register in [1:0] |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered combined interrupt request |
| fiq | output | 1 | Registered fast interrupt request |

## Verification
The assertions assume that every input is synchronous to clk, that bus_we and the inputs stay low during reset, and that a latched bit's clear comes only from a bank A request write. The stimulus changes all inputs half a period away from the active edge, keeps them at zero through reset, and gives each edge-latched input a clean low-to-high step. The one overlap it creates on purpose is the same-cycle edge and clear from R5.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int GRP_W  = 2;
  localparam int SEL_W  = 2;
  localparam int ADDR_W = GRP_W + SEL_W;
  localparam int NGRP   = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_STAT = 2'd0,
    SEL_REQ  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam logic [GRP_W-1:0] GRP_A = 2'd0;
  localparam logic [GRP_W-1:0] GRP_B = 2'd1;
  localparam logic [GRP_W-1:0] GRP_F = 2'd2;
endpackage

// File: rtl/intc_src_bank.sv
module intc_src_bank #(
  parameter int           W        = 8,
  parameter logic [W-1:0] EDGE_SEL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (EDGE_SEL[i]) begin : g_edge
      logic prev_q;
      logic lat_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          prev_q <= 1'b0;
          lat_q  <= 1'b0;
        end else begin
          prev_q <= src[i];
          lat_q  <= (lat_q & ~clr[i]) | (src[i] & ~prev_q);
        end
      end
      assign status[i] = lat_q;

      // R3
      edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lat_q && !clr[i]) |=> lat_q);
      // R5
      set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (src[i] && !prev_q && clr[i]) |=> lat_q);
    end else begin : g_lvl
      assign status[i] = src[i];
    end
  end

  logic unused_clr;
  assign unused_clr = ^(clr & ~EDGE_SEL);
endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
  import intc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      stat_a,
  input  logic [W-1:0]      stat_b,
  input  logic [W-1:0]      stat_f,
  output logic [W-1:0]      mask_a,
  output logic [W-1:0]      mask_b,
  output logic [W-1:0]      mask_f,
  output logic [W-1:0]      req_a,
  output logic [W-1:0]      req_b,
  output logic [W-1:0]      req_f,
  output logic [W-1:0]      clr_a,
  output logic [W-1:0]      rdata
);
  logic [GRP_W-1:0] grp;
  reg_sel_e         sel;
  logic [W-1:0]     mask_q [NGRP];
  logic [W-1:0]     stat_v [NGRP];
  logic [W-1:0]     req_v  [NGRP];

  assign grp = addr[ADDR_W-1:SEL_W];
  assign sel = reg_sel_e'(addr[SEL_W-1:0]);

  assign stat_v[0] = stat_a;
  assign stat_v[1] = stat_b;
  assign stat_v[2] = stat_f;

  for (genvar g = 0; g < NGRP; g++) begin : g_req
    assign req_v[g] = stat_v[g] & mask_q[g];
  end

  assign mask_a = mask_q[0];
  assign mask_b = mask_q[1];
  assign mask_f = mask_q[2];
  assign req_a  = req_v[0];
  assign req_b  = req_v[1];
  assign req_f  = req_v[2];

  assign clr_a = (we && grp == GRP_A && sel == SEL_REQ) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < NGRP; g++) mask_q[g] <= '0;
    end else if (we && sel == SEL_MASK) begin
      for (int g = 0; g < NGRP; g++)
        if (grp == GRP_W'(g)) mask_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      for (int g = 0; g < NGRP; g++) begin
        if (grp == GRP_W'(g)) begin
          case (sel)
            SEL_STAT: rdata <= stat_v[g];
            SEL_REQ:  rdata <= req_v[g];
            SEL_MASK: rdata <= mask_q[g];
            default:  rdata <= '0;
          endcase
        end
      end
    end
  end

  // R9
  mask_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == {GRP_A, SEL_MASK}) |=> (mask_a == $past(wdata)));
  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (addr[SEL_W-1:0] == SEL_NONE || addr[ADDR_W-1:SEL_W] == 2'd3) |=> (rdata == '0));
endmodule

// File: rtl/intc_out.sv
module intc_out #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] req_a,
  input  logic [W-1:0] req_b,
  input  logic [W-1:0] req_f,
  output logic         irq,
  output logic         fiq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
      fiq <= 1'b0;
    end else begin
      irq <= |{req_a, req_b};
      fiq <= |req_f;
    end
  end
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int           W      = 8,
  parameter logic [W-1:0] EDGE_A = 8'h64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      src_a,
  input  logic [W-1:0]      src_b,
  input  logic [W-1:0]      src_f,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              irq,
  output logic              fiq
);
  logic [W-1:0] stat_a, stat_b, stat_f;
  logic [W-1:0] mask_a, mask_b, mask_f;
  logic [W-1:0] req_a, req_b, req_f;
  logic [W-1:0] clr_a;

  intc_src_bank #(.W(W), .EDGE_SEL(EDGE_A)) u_bank_a (
    .clk(clk), .rst(rst), .src(src_a), .clr(clr_a), .status(stat_a));
  intc_src_bank #(.W(W), .EDGE_SEL('0)) u_bank_b (
    .clk(clk), .rst(rst), .src(src_b), .clr('0), .status(stat_b));
  intc_src_bank #(.W(W), .EDGE_SEL('0)) u_bank_f (
    .clk(clk), .rst(rst), .src(src_f), .clr('0), .status(stat_f));

  intc_regfile #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .stat_a(stat_a), .stat_b(stat_b), .stat_f(stat_f),
    .mask_a(mask_a), .mask_b(mask_b), .mask_f(mask_f),
    .req_a(req_a), .req_b(req_b), .req_f(req_f),
    .clr_a(clr_a), .rdata(bus_rdata));

  intc_out #(.W(W)) u_out (
    .clk(clk), .rst(rst), .req_a(req_a), .req_b(req_b), .req_f(req_f),
    .irq(irq), .fiq(fiq));

  // R7
  irq_block_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_a == '0 && mask_b == '0) |=> !irq);
  // R8
  fiq_block_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_f == '0) |=> !fiq);
endmodule

// File: tb/dual_bank_intc_bench.sv
module dual_bank_intc_bench;
  localparam logic [3:0] A_STAT = 4'h0, A_REQ = 4'h1, A_MASK = 4'h2;
  localparam logic [3:0] B_STAT = 4'h4, B_REQ = 4'h5, B_MASK = 4'h6;
  localparam logic [3:0] F_STAT = 4'h8, F_REQ = 4'h9, F_MASK = 4'hA;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] src_a = '0, src_b = '0, src_f = '0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, fiq;

  always #2 clk = ~clk;

  dual_bank_intc u_dual_bank_intc (
    .clk(clk), .rst(rst), .src_a(src_a), .src_b(src_b), .src_f(src_f),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .fiq(fiq));

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
    int         due;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = {7'b0, irq};
        default: act = {7'b0, fiq};
      endcase
      n_tests++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [7:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag; it.due = cyc + 1;
    sb.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    push(0, exp, tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(A_MASK, 8'h00, "R1 mask A");
    rd(B_MASK, 8'h00, "R1 mask B");
    rd(F_MASK, 8'h00, "R1 mask F");
    rd(A_STAT, 8'h00, "R1 latched bits");
    push(1, 8'h00, "R1 irq");
    push(2, 8'h00, "R1 fiq");
    tick();
    // R9 mask readback, status write ignored
    wr(A_MASK, 8'hFF);
    rd(A_MASK, 8'hFF, "R9 mask A readback");
    wr(B_MASK, 8'h0F);
    rd(B_MASK, 8'h0F, "R9 mask B readback");
    wr(A_STAT, 8'h55);
    rd(A_STAT, 8'h00, "R9 status write ignored");
    wr(A_MASK, 8'h00);
    // R2 level inputs
    src_a = 8'h01;
    rd(A_STAT, 8'h01, "R2 level bit high");
    src_a = 8'h00;
    rd(A_STAT, 8'h00, "R2 level bit follows low");
    src_b = 8'h81;
    rd(B_STAT, 8'h81, "R2 bank B level");
    // R6 request = status & mask
    rd(B_REQ, 8'h01, "R6 bank B request");
    push(1, 8'h01, "R7 irq from bank B");
    tick();
    wr(B_MASK, 8'h00);
    tick();
    push(1, 8'h00, "R7 zero masks block irq");
    tick();
    // R4 bank B request write ignored
    wr(B_REQ, 8'hFF);
    rd(B_STAT, 8'h81, "R4 bank B request write ignored");
    src_b = 8'h00;
    // R3 timer expiry pulse latched
    wr(A_MASK, 8'hFF);
    src_a = 8'h20;
    tick();
    src_a = 8'h00;
    tick();
    rd(A_STAT, 8'h20, "R3 timer pulse latched");
    rd(A_REQ, 8'h20, "R6 bank A request");
    push(1, 8'h01, "R7 irq from latched bit");
    tick();
    // R4 selective clear
    wr(A_REQ, 8'h04);
    rd(A_STAT, 8'h20, "R4 unselected bit kept");
    wr(A_REQ, 8'h20);
    rd(A_STAT, 8'h00, "R4 selected bit cleared");
    push(1, 8'h00, "R4 irq drops after clear");
    tick();
    src_a = 8'h01;
    wr(A_REQ, 8'hFF);
    rd(A_STAT, 8'h01, "R4 level bit unaffected by clear");
    src_a = 8'h00;
    // R3 held-high input does not refire
    src_a = 8'h04;
    tick();
    wr(A_REQ, 8'h04);
    rd(A_STAT, 8'h00, "R3 held input no second set");
    src_a = 8'h00;
    tick();
    // R5 set wins over same-cycle clear
    src_a = 8'h40;
    bus_addr = A_REQ; bus_we = 1'b1; bus_wdata = 8'h40;
    tick();
    bus_we = 1'b0; bus_wdata = 8'h00; src_a = 8'h00;
    rd(A_STAT, 8'h40, "R5 set wins");
    wr(A_REQ, 8'hFF);
    wr(A_MASK, 8'h00);
    // R8 fast interrupt
    src_f = 8'h03;
    tick();
    push(2, 8'h00, "R8 fiq masked");
    tick();
    wr(F_MASK, 8'h02);
    tick();
    push(2, 8'h01, "R8 fiq raised");
    tick();
    rd(F_STAT, 8'h03, "R8 fast status");
    rd(F_REQ, 8'h02, "R8 fast request");
    push(1, 8'h00, "R8 fast group not on irq");
    tick();
    // R10 unmapped addresses
    rd(4'h3, 8'h00, "R10 unmapped reg");
    rd(4'hF, 8'h00, "R10 unmapped group");
    rd(4'hC, 8'h00, "R10 unmapped group status");
    tick();
    tick();
    while (sb.size() > 0) tick();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule